// File: doc/BRIEF.md
# Selectable Interrupt Source Controller

This block turns one of three event sources into a single latched interrupt request and places that request on one of several bus request lines. The sources are an asynchronous external input, a one-cycle pulse from a DMA engine that has reached terminal count, and a one-cycle pulse from a counter that has reached terminal count. The external input is synchronized and edge-detected, and software picks the edge direction.

Software writes one control word. It holds the source, the edge polarity, a global enable, a request-line number and a one-shot clear bit. The status word can be read at any time and returns the stored fields together with the pending flag. A selected event sets the pending flag. The flag stays set until software clears it. While the flag is set, the enable is on and the line number lies within the allowed range, exactly one request line is high.

Top module: `irq_source_sel`

## Requirements
- R1: After reset the status word reads zero and no request line is high.
- R2: The control word has five fields. Bits [1:0] are the source. Bit 2 is the polarity. Bit 3 is the enable. Bits [7:4] are the line number. Bit 8 is clear. Source codes: 0 external, 1 DMA terminal count, 2 counter terminal count, 3 none. The status word returns pending in bit 8 and the stored fields in bits [7:0], at the same positions as in the control word. The stored fields are visible on the cycle after the write.
- R3: Only the selected source can set pending. Pulses and edges on the other sources have no effect on the pending flag.
- R4: With the external source selected, polarity 1 reacts to a rising edge and polarity 0 reacts to a falling edge. Pending is visible three clock edges after the input change is first sampled.
- R5: Pending stays set until a write with the clear bit high. If a selected event arrives in the same cycle as a clear, the event wins and pending remains set.
- R6: With the enable at 0, no request line is high. Events are still recorded in the pending flag.
- R7: When pending and enable are both 1 and the line number is in 2..15, the only line that is high is the one whose index equals the line number.
- R8: A line number below 2 or above 15 drives no request line.
- R9: A write that changes the source or the polarity resets the edge history to the synchronizer's next value. An external transition that is still inside the synchronizer at the time of that write is not reported.
- R10: Source code 3 never sets pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| extIn | input | 1 | Asynchronous external interrupt input |
| dmaTc | input | 1 | DMA terminal-count pulse |
| cntTc | input | 1 | Counter terminal-count pulse |
| wrEn | input | 1 | Control word write strobe |
| wrData | input | 9 | Control word (source, polarity, enable, line, clear) |
| rdData | output | 9 | Status word (pending and stored fields) |
| irqReq | output | 16 | Request lines, at most one high |

## Verification
The hardest case to reach is the history reset on a source or polarity change. The write must arrive exactly one cycle after an external transition enters the synchronizer, so that the edge is still in flight when the configuration changes. A directed sequence creates this case. It changes the input at one falling clock edge and issues the write at the next falling edge. It then checks that pending stays clear. Randomized rounds cover the remaining cases. Each round picks a source, a polarity, an enable, a line number and an event kind, and the bench predicts the flag and the line from those choices.

// File: rtl/irqsel_pkg.sv
package irqsel_pkg;
  typedef enum logic [1:0] {
    SRC_EXT = 2'd0,
    SRC_DMA = 2'd1,
    SRC_CNT = 2'd2,
    SRC_OFF = 2'd3
  } srcSel_e;

  typedef struct packed {
    logic clearPend;
    logic flushHist;
  } ctrlStrobe_t;
endpackage

// File: rtl/irqsel_ctrl.sv
module irqsel_ctrl
  import irqsel_pkg::*;
#(
  parameter int LVL_W = 4,
  localparam int WR_W = LVL_W + 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [WR_W-1:0]  wrData,
  output srcSel_e          srcSel,
  output logic             polRise,
  output logic             irqEn,
  output logic [LVL_W-1:0] level,
  output ctrlStrobe_t      strobe
);
  localparam int LVL_LO = 4;
  localparam int CLR_BIT = LVL_LO + LVL_W;

  srcSel_e newSrc;
  logic newPol;

  assign newSrc = srcSel_e'(wrData[1:0]);
  assign newPol = wrData[2];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      srcSel  <= SRC_EXT;
      polRise <= 1'b0;
      irqEn   <= 1'b0;
      level   <= '0;
    end else if (wrEn) begin
      srcSel  <= newSrc;
      polRise <= newPol;
      irqEn   <= wrData[3];
      level   <= wrData[CLR_BIT-1:LVL_LO];
    end
  end

  always_comb begin
    strobe.clearPend = wrEn && wrData[CLR_BIT];
    strobe.flushHist = wrEn && ((newSrc != srcSel) || (newPol != polRise));
  end
endmodule

// File: rtl/irqsel_dp.sv
module irqsel_dp
  import irqsel_pkg::*;
#(
  parameter int NUM_LINES = 16,
  parameter int LVL_MIN = 2,
  parameter int LVL_MAX = 15,
  parameter int LVL_W = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 extIn,
  input  logic                 dmaTc,
  input  logic                 cntTc,
  input  srcSel_e              srcSel,
  input  logic                 polRise,
  input  logic                 irqEn,
  input  logic [LVL_W-1:0]     level,
  input  ctrlStrobe_t          strobe,
  output logic                 pending,
  output logic [NUM_LINES-1:0] irqReq
);
  logic syncA, syncB, extPrev;
  logic extHit, evtHit, lineActive;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncA   <= 1'b0;
      syncB   <= 1'b0;
      extPrev <= 1'b0;
    end else begin
      syncA   <= extIn;
      syncB   <= syncA;
      extPrev <= strobe.flushHist ? syncA : syncB;
    end
  end

  assign extHit = polRise ? (syncB && !extPrev) : (!syncB && extPrev);

  always_comb begin
    unique case (srcSel)
      SRC_EXT: evtHit = extHit;
      SRC_DMA: evtHit = dmaTc;
      SRC_CNT: evtHit = cntTc;
      default: evtHit = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN)                pending <= 1'b0;
    else if (evtHit)          pending <= 1'b1;
    else if (strobe.clearPend) pending <= 1'b0;
  end

  assign lineActive = pending && irqEn;

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    if (i >= LVL_MIN && i <= LVL_MAX) begin : g_used
      assign irqReq[i] = lineActive && (level == LVL_W'(i));
    end else begin : g_unused
      assign irqReq[i] = 1'b0;
    end
  end
endmodule

// File: rtl/irq_source_sel.sv
module irq_source_sel
  import irqsel_pkg::*;
#(
  parameter int NUM_LINES = 16,
  parameter int LVL_MIN = 2,
  parameter int LVL_MAX = 15,
  localparam int LVL_W = $clog2(NUM_LINES),
  localparam int WR_W = LVL_W + 5
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 extIn,
  input  logic                 dmaTc,
  input  logic                 cntTc,
  input  logic                 wrEn,
  input  logic [WR_W-1:0]      wrData,
  output logic [WR_W-1:0]      rdData,
  output logic [NUM_LINES-1:0] irqReq
);
  srcSel_e srcSel;
  logic polRise, irqEn, pending;
  logic [LVL_W-1:0] level;
  ctrlStrobe_t strobe;

  irqsel_ctrl #(.LVL_W(LVL_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData),
    .srcSel(srcSel), .polRise(polRise), .irqEn(irqEn), .level(level),
    .strobe(strobe)
  );

  irqsel_dp #(
    .NUM_LINES(NUM_LINES), .LVL_MIN(LVL_MIN), .LVL_MAX(LVL_MAX), .LVL_W(LVL_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .extIn(extIn), .dmaTc(dmaTc), .cntTc(cntTc),
    .srcSel(srcSel), .polRise(polRise), .irqEn(irqEn), .level(level),
    .strobe(strobe), .pending(pending), .irqReq(irqReq)
  );

  assign rdData = {pending, level, irqEn, polRise, srcSel};
endmodule

// File: rtl/irqsel_chk.sv
module irqsel_chk #(
  parameter int NUM_LINES = 16,
  parameter int LVL_MIN = 2,
  parameter int LVL_MAX = 15,
  localparam int LVL_W = $clog2(NUM_LINES),
  localparam int WR_W = LVL_W + 5
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 dmaTc,
  input logic                 wrEn,
  input logic [WR_W-1:0]      wrData,
  input logic [WR_W-1:0]      rdData,
  input logic [NUM_LINES-1:0] irqReq
);
  logic pend, en, inRange;
  logic [1:0] src;
  logic [LVL_W-1:0] lvl;

  assign pend = rdData[WR_W-1];
  assign lvl = rdData[WR_W-2:4];
  assign en = rdData[3];
  assign src = rdData[1:0];
  assign inRange = (int'(lvl) >= LVL_MIN) && (int'(lvl) <= LVL_MAX);

  a_r7_at_most_one: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(irqReq));
  a_r6_disabled_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !en |-> irqReq == '0);
  a_r8_range_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !inRange |-> irqReq == '0);
  a_r7_line_match: assert property (@(posedge clk) disable iff (!rstN)
    (pend && en && inRange) |-> irqReq == (NUM_LINES'(1) << lvl));
  a_r5_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (pend && !(wrEn && wrData[WR_W-1])) |=> pend);
  a_r3_dma_sets: assert property (@(posedge clk) disable iff (!rstN)
    (src == 2'd1 && dmaTc) |=> pend);
  a_r10_off_never: assert property (@(posedge clk) disable iff (!rstN)
    (src == 2'd3 && !pend) |=> !pend);
endmodule

bind irq_source_sel irqsel_chk #(
  .NUM_LINES(NUM_LINES), .LVL_MIN(LVL_MIN), .LVL_MAX(LVL_MAX)
) u_chk (
  .clk(clk), .rstN(rstN), .dmaTc(dmaTc), .wrEn(wrEn), .wrData(wrData),
  .rdData(rdData), .irqReq(irqReq)
);

// File: tb/test_irq_source_sel.sv
`timescale 1ns/1ps
module test_irq_source_sel;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic extIn = 1'b0, dmaTc = 1'b0, cntTc = 1'b0, wrEn = 1'b0;
  logic [8:0] wrData = '0;
  logic [8:0] rdData;
  logic [15:0] irqReq;
  int nChecks = 0, nFails = 0;

  always #2 clk = ~clk;

  irq_source_sel i_irq_source_sel (
    .clk(clk), .rstN(rstN), .extIn(extIn), .dmaTc(dmaTc), .cntTc(cntTc),
    .wrEn(wrEn), .wrData(wrData), .rdData(rdData), .irqReq(irqReq)
  );

  function automatic logic [15:0] expLines(logic pend, logic en, logic [3:0] lvl);
    if (pend && en && lvl >= 4'd2 && lvl <= 4'd15) return 16'(1) << lvl;
    return '0;
  endfunction

  function automatic logic [8:0] expStat(logic pend, logic [3:0] lvl, logic en,
                                         logic pol, logic [1:0] src);
    return {pend, lvl, en, pol, src};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic writeCfg(logic [1:0] src, logic pol, logic en, logic [3:0] lvl, logic clr);
    @(negedge clk);
    wrEn = 1'b1;
    wrData = {clr, lvl, en, pol, src};
    @(negedge clk);
    wrEn = 1'b0;
    wrData = '0;
  endtask

  task automatic pulseDma();
    @(negedge clk); dmaTc = 1'b1;
    @(negedge clk); dmaTc = 1'b0;
  endtask

  task automatic pulseCnt();
    @(negedge clk); cntTc = 1'b1;
    @(negedge clk); cntTc = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    idle(3);
    rstN = 1'b1;
    idle(1);
    check("R1 status", rdData, 0);
    check("R1 lines", irqReq, 0);

    writeCfg(2'd2, 1'b1, 1'b1, 4'd9, 1'b0);
    check("R2 readback", rdData, expStat(0, 9, 1, 1, 2));

    writeCfg(2'd1, 1'b0, 1'b1, 4'd5, 1'b1);
    pulseCnt();
    idle(2);
    check("R3 counter ignored", rdData[8], 0);
    pulseDma();
    check("R3 dma sets", rdData[8], 1);
    check("R7 line five", irqReq, 16'h0020);
    writeCfg(2'd1, 1'b0, 1'b1, 4'd5, 1'b0);
    check("R5 held without clear", rdData[8], 1);
    writeCfg(2'd1, 1'b0, 1'b1, 4'd5, 1'b1);
    check("R5 cleared", rdData[8], 0);
    @(negedge clk);
    wrEn = 1'b1; wrData = {1'b1, 4'd5, 1'b1, 1'b0, 2'd1}; dmaTc = 1'b1;
    @(negedge clk);
    wrEn = 1'b0; wrData = '0; dmaTc = 1'b0;
    check("R5 event beats clear", rdData[8], 1);

    writeCfg(2'd1, 1'b0, 1'b0, 4'd5, 1'b0);
    check("R6 lines off", irqReq, 0);
    check("R6 pending kept", rdData[8], 1);
    writeCfg(2'd1, 1'b0, 1'b1, 4'd1, 1'b0);
    check("R8 level one", irqReq, 0);
    writeCfg(2'd1, 1'b0, 1'b1, 4'd0, 1'b0);
    check("R8 level zero", irqReq, 0);
    writeCfg(2'd1, 1'b0, 1'b1, 4'd15, 1'b0);
    check("R7 level fifteen", irqReq, 16'h8000);
    writeCfg(2'd1, 1'b0, 1'b1, 4'd2, 1'b0);
    check("R7 level two", irqReq, 16'h0004);

    writeCfg(2'd3, 1'b1, 1'b1, 4'd3, 1'b1);
    pulseDma();
    pulseCnt();
    @(negedge clk); extIn = 1'b1;
    idle(4);
    @(negedge clk); extIn = 1'b0;
    idle(4);
    check("R10 none selected", rdData[8], 0);

    writeCfg(2'd2, 1'b1, 1'b1, 4'd3, 1'b1);
    idle(3);
    @(negedge clk); extIn = 1'b1;
    writeCfg(2'd0, 1'b1, 1'b1, 4'd3, 1'b0);
    idle(4);
    check("R9 in-flight edge dropped", rdData[8], 0);
    @(negedge clk); extIn = 1'b0;
    idle(4);
    @(negedge clk); extIn = 1'b1;
    idle(3);
    check("R4 rising after flush", rdData[8], 1);

    for (int it = 0; it < 40; it++) begin
      logic [1:0] src, kind;
      logic pol, en, start, expPend;
      logic [3:0] lvl;
      src = 2'($urandom_range(0, 3));
      kind = 2'($urandom_range(0, 2));
      pol = 1'($urandom_range(0, 1));
      en = 1'($urandom_range(0, 1));
      start = 1'($urandom_range(0, 1));
      lvl = 4'($urandom_range(0, 15));
      if (it == 0) begin src = 2'd0; kind = 2'd0; pol = 1'b0; start = 1'b1; en = 1'b1; lvl = 4'd7; end
      @(negedge clk); extIn = start;
      idle(4);
      writeCfg(src, pol, en, lvl, 1'b1);
      check("R2 random readback", rdData, expStat(0, lvl, en, pol, src));
      case (kind)
        2'd0: begin @(negedge clk); extIn = ~start; idle(4); end
        2'd1: pulseDma();
        default: pulseCnt();
      endcase
      expPend = (kind == src) && (kind != 2'd0 || pol == ~start);
      check("R3 R4 R10 random pending", rdData[8], expPend);
      check("R6 R7 R8 random lines", irqReq, expLines(expPend, en, lvl));
    end

    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule